// File: doc/BRIEF.md
# Energy-Delivery Interlock Supervisor

This block is the safety supervisor that sits between an ablation generator's controller and its power-amplifier enable. It watches seven conditions: probe presence, door closure, the operator footswitch, the emergency stop, a controller heartbeat, a fast mismatch fault and a temperature-trend fault. It decides whether energy may flow. The three mechanical inputs pass through counter debouncers. The fault sources are ranked by a fixed priority, and the highest active one is reported as a reason code.

Every trip is latched. It clears only when an operator reset pulse arrives while no fault source is active. If the latched cause was the emergency stop, a passed self-check is needed as well. The emergency stop and the heartbeat timeout reach the trip output without passing through the state register, so they act even if the state flow is wrong. Releasing the footswitch does not cut energy at once: it starts a fixed ramp-down window.

The state machine has six states:
- LOCKED: the power-up state.
- ARMED: ready, no energy.
- DELIVER: energy permitted.
- RAMP: ramp-down in progress.
- HOLD: paused after a probe loss.
- TRIPPED: latched fault.

The transitions are:
- LOCKED→ARMED: reset pulse, no fault active, self-check passed.
- ARMED→DELIVER: footswitch down and probe valid.
- DELIVER→RAMP: footswitch released.
- RAMP→ARMED: ramp window elapsed.
- DELIVER/RAMP→HOLD: probe lost.
- HOLD→ARMED: reset pulse with probe valid.
- ARMED/DELIVER/RAMP/HOLD→TRIPPED: any latching fault.
- TRIPPED→ARMED: reset pulse, sources clear, and self-check passed if the cause was the emergency stop.

Top module: `intlk_supervisor`

## Requirements
- R1: After reset, permit, trip, ramp request, trip strobe and reason are all 0. The block stays LOCKED, ignoring the footswitch, until a reset pulse arrives with self-check passed and no fault active.
- R2: Probe, door and footswitch changes are accepted only after DB_CYC consecutive cycles at the new level. A shorter excursion has no effect on permit or trip.
- R3: The reason code is 1 for emergency stop, 2 for heartbeat timeout, 3 for door open, 4 for mismatch, 5 for temperature trend and 6 for probe loss; 0 means no reason. A lower code has higher priority. While tripped, a newly active higher-priority source replaces the code.
- R4: trip_evt is a one-cycle strobe, issued each time a trip reason is set or upgraded.
- R5: The emergency stop raises trip in the same cycle, combinationally, and permit is low at the next edge. Clearing a trip caused by it also requires selfcheck_ok.
- R6: If no heartbeat arrives for WD_CYC cycles, trip is raised. The trip stays latched after heartbeats return, and the reason code is 2.
- R7: An open door, a mismatch fault or a temperature-trend fault latches TRIPPED: trip is 1 and permit is 0 until a valid reset. After that reset the block re-arms with reason 0.
- R8: A reset pulse is ignored while any latching source is still active.
- R9: An invalid probe blocks the start from ARMED. During delivery it forces HOLD: permit 0, trip 0, reason 6. Delivery resumes only after a reset pulse given while the probe is valid.
- R10: Pressing the footswitch with a valid probe gives permit. Releasing it gives exactly RAMP_CYC cycles with ramp_req and permit both high, then ARMED with permit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_ok_i | input | 1 | Probe present and identified (raw) |
| door_shut_i | input | 1 | Door/cover closed (raw) |
| foot_dn_i | input | 1 | Footswitch pressed (raw) |
| estop_i | input | 1 | Emergency stop active |
| hb_i | input | 1 | Controller heartbeat, one per cycle high counts |
| mismatch_i | input | 1 | Fast reflected-power fault flag |
| temp_trend_i | input | 1 | Temperature-trend fault flag |
| clr_req_i | input | 1 | Operator reset pulse |
| selfcheck_ok_i | input | 1 | Self-check passed |
| permit_o | output | 1 | Permit to energize |
| trip_o | output | 1 | Trip / hard disable |
| ramp_req_o | output | 1 | Ramp-down request |
| reason_o | output | 3 | Reason code of the winning fault |
| trip_evt_o | output | 1 | One-cycle strobe on reason set or upgrade |

## Verification
All fifteen non-empty combinations of emergency stop, door open, mismatch and temperature-trend faults are injected during delivery. For each combination the expected reason and strobe count are worked out from the priority order. Because the door arrives late through its debouncer, these combinations separate correct ranking from a first-come code and show the upgrade strobe. Short glitches on the door and footswitch, shorter than the debounce window, separate debouncing from raw sampling. Probe-loss, heartbeat-gap and self-check-withheld sequences separate pause from trip, a near-miss heartbeat gap from a timeout, and plain recovery from the recovery the emergency stop requires.

// File: rtl/intlk_pkg.sv
package intlk_pkg;

    typedef enum logic [2:0] {
        ST_LOCKED,
        ST_ARMED,
        ST_DELIVER,
        ST_RAMP,
        ST_HOLD,
        ST_TRIPPED
    } sup_state_t;

    typedef enum logic [2:0] {
        RSN_NONE     = 3'd0,
        RSN_ESTOP    = 3'd1,
        RSN_WDOG     = 3'd2,
        RSN_DOOR     = 3'd3,
        RSN_MISMATCH = 3'd4,
        RSN_TEMP     = 3'd5,
        RSN_PROBE    = 3'd6
    } rsn_t;

    function automatic rsn_t pick_winner(input logic estop, input logic wdog,
                                         input logic door_open, input logic mism,
                                         input logic temp);
        rsn_t r;
        if (estop)          r = RSN_ESTOP;
        else if (wdog)      r = RSN_WDOG;
        else if (door_open) r = RSN_DOOR;
        else if (mism)      r = RSN_MISMATCH;
        else if (temp)      r = RSN_TEMP;
        else                r = RSN_NONE;
        return r;
    endfunction

endpackage

// File: rtl/intlk_debounce.sv
module intlk_debounce #(
    parameter int STABLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            clean_o <= 1'b0;
        end else if (raw_i != clean_o) begin
            if (cnt_q == CW'(STABLE_CYC - 1)) begin
                clean_o <= raw_i;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    AST_DB_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_o != $past(clean_o)) |-> ($past(raw_i) == clean_o)); // R2

endmodule

// File: rtl/intlk_hb_watch.sv
module intlk_hb_watch #(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_i,
    output logic timeout_o
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (hb_i)
            cnt_q <= '0;
        else if (cnt_q != CW'(TIMEOUT_CYC))
            cnt_q <= cnt_q + 1'b1;
    end

    assign timeout_o = (cnt_q == CW'(TIMEOUT_CYC));

    AST_HB_CLEARS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        hb_i |=> !timeout_o); // R6

endmodule

// File: rtl/intlk_supervisor.sv
module intlk_supervisor
    import intlk_pkg::*;
#(
    parameter int DB_CYC   = 8,
    parameter int WD_CYC   = 1000,
    parameter int RAMP_CYC = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       probe_ok_i,
    input  logic       door_shut_i,
    input  logic       foot_dn_i,
    input  logic       estop_i,
    input  logic       hb_i,
    input  logic       mismatch_i,
    input  logic       temp_trend_i,
    input  logic       clr_req_i,
    input  logic       selfcheck_ok_i,
    output logic       permit_o,
    output logic       trip_o,
    output logic       ramp_req_o,
    output logic [2:0] reason_o,
    output logic       trip_evt_o
);
    localparam int NMECH = 3;
    localparam int RW    = $clog2(RAMP_CYC + 1);

    // Mechanical inputs: index 0 probe, 1 door, 2 footswitch
    logic [NMECH-1:0] mech_raw, mech_db;
    assign mech_raw = {foot_dn_i, door_shut_i, probe_ok_i};

    for (genvar g = 0; g < NMECH; g++) begin : g_db
        intlk_debounce #(.STABLE_CYC(DB_CYC)) u_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (mech_raw[g]),
            .clean_o(mech_db[g])
        );
    end

    logic probe_db, door_db, foot_db;
    assign probe_db = mech_db[0];
    assign door_db  = mech_db[1];
    assign foot_db  = mech_db[2];

    logic wd_to;
    intlk_hb_watch #(.TIMEOUT_CYC(WD_CYC)) u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .hb_i     (hb_i),
        .timeout_o(wd_to)
    );

    logic latch_flt;
    rsn_t win;
    assign latch_flt = estop_i | wd_to | ~door_db | mismatch_i | temp_trend_i;
    assign win       = pick_winner(estop_i, wd_to, ~door_db, mismatch_i, temp_trend_i);

    sup_state_t st_q, st_d;
    rsn_t       rsn_q;
    logic       evt_q;
    logic [RW-1:0] ramp_cnt_q;
    logic       ramp_done;
    logic       clear_ok;

    assign ramp_done = (ramp_cnt_q == RW'(RAMP_CYC - 1));
    assign clear_ok  = clr_req_i && !latch_flt &&
                       ((rsn_q != RSN_ESTOP) || selfcheck_ok_i);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LOCKED:  if (clr_req_i && !latch_flt && selfcheck_ok_i) st_d = ST_ARMED;
            ST_ARMED: begin
                if (latch_flt)                st_d = ST_TRIPPED;
                else if (foot_db && probe_db) st_d = ST_DELIVER;
            end
            ST_DELIVER: begin
                if (latch_flt)     st_d = ST_TRIPPED;
                else if (!probe_db) st_d = ST_HOLD;
                else if (!foot_db)  st_d = ST_RAMP;
            end
            ST_RAMP: begin
                if (latch_flt)      st_d = ST_TRIPPED;
                else if (!probe_db) st_d = ST_HOLD;
                else if (ramp_done) st_d = ST_ARMED;
            end
            ST_HOLD: begin
                if (latch_flt)                   st_d = ST_TRIPPED;
                else if (clr_req_i && probe_db)  st_d = ST_ARMED;
            end
            ST_TRIPPED: if (clear_ok) st_d = ST_ARMED;
            default:    st_d = ST_LOCKED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_LOCKED;
        else        st_q <= st_d;
    end

    // Ramp window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               ramp_cnt_q <= '0;
        else if (st_q == ST_RAMP) ramp_cnt_q <= ramp_cnt_q + 1'b1;
        else                      ramp_cnt_q <= '0;
    end

    // Reason code and trip strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsn_q <= RSN_NONE;
            evt_q <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            if (st_d == ST_TRIPPED && win != RSN_NONE &&
                (st_q != ST_TRIPPED || win < rsn_q)) begin
                rsn_q <= win;
                evt_q <= 1'b1;
            end else if (st_d == ST_HOLD && st_q != ST_HOLD) begin
                rsn_q <= RSN_PROBE;
            end else if (st_d == ST_ARMED || st_d == ST_LOCKED) begin
                rsn_q <= RSN_NONE;
            end
        end
    end

    // Outputs; emergency stop and heartbeat loss bypass the state register
    always_comb begin
        permit_o   = (st_q == ST_DELIVER) || (st_q == ST_RAMP);
        ramp_req_o = (st_q == ST_RAMP);
        trip_o     = estop_i || wd_to || (st_q == ST_TRIPPED);
        reason_o   = rsn_q;
        trip_evt_o = evt_q;
    end

    AST_ESTOP_KILLS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        estop_i |=> !permit_o); // R5

    AST_NO_AUTO_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_ARMED) && (($past(st_q) == ST_TRIPPED) || ($past(st_q) == ST_HOLD)))
        |-> $past(clr_req_i)); // R7

    AST_ESTOP_NEEDS_SELFCHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st_q) == ST_TRIPPED) && ($past(rsn_q) == RSN_ESTOP) && (st_q == ST_ARMED))
        |-> $past(selfcheck_ok_i)); // R5

    AST_RESET_BLOCKED_BY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_TRIPPED) && latch_flt) |=> (st_q == ST_TRIPPED)); // R8

    AST_PROBE_LOSS_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !probe_db |=> !permit_o); // R9

    AST_EVT_HAS_REASON: assert property (@(posedge clk) disable iff (!rst_n)
        trip_evt_o |-> (trip_o && reason_o != 3'd0)); // R4

endmodule

// File: tb/intlk_supervisor_test.sv
module intlk_supervisor_test;
    localparam int DB = 4;
    localparam int WD = 16;
    localparam int RP = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic probe = 1'b1, door = 1'b1, foot = 1'b0, estop = 1'b0, hb = 1'b1;
    logic mism = 1'b0, temp = 1'b0, clr = 1'b0, sc = 1'b0;
    logic permit, trip, ramp, evt;
    logic [2:0] reason;

    int checks = 0;
    int failures = 0;
    int evt_cnt = 0;
    int cyc_cnt = 0;

    always #10 clk = ~clk;

    intlk_supervisor #(.DB_CYC(DB), .WD_CYC(WD), .RAMP_CYC(RP)) uut (
        .clk(clk), .rst_n(rst_n), .probe_ok_i(probe), .door_shut_i(door),
        .foot_dn_i(foot), .estop_i(estop), .hb_i(hb), .mismatch_i(mism),
        .temp_trend_i(temp), .clr_req_i(clr), .selfcheck_ok_i(sc),
        .permit_o(permit), .trip_o(trip), .ramp_req_o(ramp),
        .reason_o(reason), .trip_evt_o(evt)
    );

    always @(negedge clk) if (evt) evt_cnt++;

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000) begin
            failures++;
            $display("FAIL watchdog: run did not finish act=%0d exp=%0d", cyc_cnt, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        cyc(1);
        clr = 1'b0;
    endtask

    initial begin
        cyc(3);
        chk("R1 reset permit", permit, 0);
        chk("R1 reset trip", trip, 0);
        chk("R1 reset reason", reason, 0);
        chk("R1 reset ramp", ramp, 0);
        chk("R1 reset evt", evt, 0);
        rst_n = 1'b1;
        cyc(DB + 3);
        foot = 1'b1;
        cyc(DB + 3);
        chk("R1 locked ignores footswitch", permit, 0);
        pulse_clr();
        cyc(3);
        chk("R1 reset without selfcheck ignored", permit, 0);
        sc = 1'b1;
        pulse_clr();
        cyc(3);
        chk("R10 deliver permit", permit, 1);
        chk("R10 deliver no trip", trip, 0);

        // R2 glitches shorter than the debounce window
        foot = 1'b0; cyc(DB - 1); foot = 1'b1;
        cyc(DB + 3);
        chk("R2 foot glitch permit", permit, 1);
        chk("R2 foot glitch ramp", ramp, 0);
        door = 1'b0; cyc(DB - 1); door = 1'b1;
        cyc(DB + 3);
        chk("R2 door glitch trip", trip, 0);
        chk("R2 door glitch permit", permit, 1);

        // R10 ramp-down window
        begin
            int rc = 0;
            int pc = 0;
            foot = 1'b0;
            for (int i = 0; i < 3 * RP + DB + 5; i++) begin
                cyc(1);
                if (ramp) begin
                    rc++;
                    if (permit) pc++;
                end
            end
            chk("R10 ramp cycles", rc, RP);
            chk("R10 permit during ramp", pc, RP);
            chk("R10 permit after ramp", permit, 0);
        end

        // R9 probe handling
        probe = 1'b0; cyc(DB + 3);
        foot = 1'b1;  cyc(DB + 3);
        chk("R9 start blocked permit", permit, 0);
        chk("R9 start blocked trip", trip, 0);
        chk("R9 start blocked reason", reason, 0);
        probe = 1'b1; cyc(DB + 3);
        chk("R9 start with probe", permit, 1);
        probe = 1'b0; cyc(DB + 3);
        chk("R9 hold permit", permit, 0);
        chk("R9 hold trip", trip, 0);
        chk("R9 hold reason", reason, 6);
        pulse_clr(); cyc(2);
        chk("R9 reset with probe invalid ignored", reason, 6);
        probe = 1'b1; cyc(DB + 3);
        chk("R9 no auto-resume", permit, 0);
        pulse_clr(); cyc(3);
        chk("R9 resume after reset", permit, 1);

        // R3 R4 R5 R7 R8 sweep over fault combinations
        for (int m = 1; m < 16; m++) begin
            bit e_b, d_b, mi_b, t_b;
            int exp_r, exp_e;
            e_b = m[0]; d_b = m[1]; mi_b = m[2]; t_b = m[3];
            exp_r = e_b ? 1 : d_b ? 3 : mi_b ? 4 : 5;
            exp_e = (d_b && !e_b && (mi_b || t_b)) ? 2 : 1;
            evt_cnt = 0;
            estop = e_b; door = !d_b; mism = mi_b; temp = t_b;
            if (e_b) begin
                #1;
                chk("R5 estop immediate trip", trip, 1);
            end
            cyc(DB + 4);
            chk("R7 tripped", trip, 1);
            chk("R7 permit low", permit, 0);
            chk("R3 reason priority", reason, exp_r);
            chk("R4 strobe count", evt_cnt, exp_e);
            pulse_clr(); cyc(2);
            chk("R8 reset ignored trip", trip, 1);
            chk("R8 reset ignored reason", reason, exp_r);
            estop = 1'b0; door = 1'b1; mism = 1'b0; temp = 1'b0;
            cyc(DB + 3);
            if (e_b) begin
                sc = 1'b0;
                pulse_clr(); cyc(2);
                chk("R5 selfcheck required", trip, 1);
                sc = 1'b1;
            end
            pulse_clr(); cyc(3);
            chk("R7 cleared trip", trip, 0);
            chk("R7 cleared reason", reason, 0);
            chk("R7 re-armed delivery", permit, 1);
        end

        // R6 heartbeat watchdog
        hb = 1'b0; cyc(WD - 2); hb = 1'b1;
        cyc(2);
        chk("R6 short gap no trip", trip, 0);
        chk("R6 short gap permit", permit, 1);
        hb = 1'b0; cyc(WD + 3);
        chk("R6 timeout trip", trip, 1);
        chk("R6 timeout reason", reason, 2);
        chk("R6 timeout permit", permit, 0);
        hb = 1'b1; cyc(2);
        chk("R6 trip latched after heartbeat", trip, 1);
        pulse_clr(); cyc(3);
        chk("R6 cleared", trip, 0);
        chk("R6 redeliver", permit, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule